// File: doc/BRIEF.md
# Serial Potentiometer Command Decoder

This block is the serial slave front end of a digitally controlled potentiometer. It samples the serial clock, data input, active-low select, pause and write-protect pins in the system clock domain. Each transaction is framed between a falling and a rising edge of select. The first byte must carry the device identifier, whose last bit matches a strapped address pin. The second byte carries an opcode and a two-bit register pointer. The block then runs one of three shapes: a two-byte transfer, a three-byte read or write, or an open-ended stream of wiper steps.

The wiper register, the four-entry data register bank and the resistor switches sit outside this block. They receive single-cycle strobes with a register pointer and a six-bit data value. Read data comes back through parallel inputs and leaves on a serial output that has a separate drive enable.

Top module: `spi_pot_decoder`

## Requirements
- R1: After reset, `so_oe_o` is low and no strobe fires. A transaction is accepted only after a falling edge of `cs_n_i` has been seen. If select is already low when reset ends, no command is taken.
- R2: The first byte is sent MSB first and must equal 0101110 followed by `addr_i`. On any mismatch, the rest of the transaction has no effect.
- R3: The second byte is opcode[7:4], pointer[3:2], 00. Opcode 1010 pulses `wiper_wr_o` and opcode 1100 pulses `dreg_wr_o`, each with the low six bits of a third byte on `wr_data_o`. The pulse comes only after all eight bits of that byte have arrived. At most one strobe is high in any cycle.
- R4: Opcode 1101 pulses `xfer_dr2w_o` and opcode 1110 pulses `xfer_w2dr_o` when the instruction byte completes, with the pointer on `reg_sel_o`. No third byte is used.
- R5: Opcode 1001 returns 00 plus the wiper value. Opcode 1011 returns 00 plus the pointed register. Opcode 0101 returns seven zeros and then `wip_i`. The byte is shifted out MSB first, and each bit changes on a falling SCK edge.
- R6: `so_oe_o` is high only while a read byte is being sent, and it drops once select rises.
- R7: After opcode 0010, each later SCK rising edge pulses `step_up_o` if SI is high or `step_dn_o` if SI is low. This continues until select rises.
- R8: If `hold_n_i` goes low while SCK is low, SCK edges are ignored and `so_oe_o` drops. If it goes high again while SCK is low, the transaction resumes at the same bit.
- R9: If select rises before a byte is complete, the transaction is cancelled and no strobe fires.
- R10: An opcode outside the eight defined values, or an instruction byte whose two low bits are not 00, is ignored until the next select falling edge.
- R11: While `wp_n_i` is low, `dreg_wr_o` and `xfer_w2dr_o` are suppressed. `wiper_wr_o` and `xfer_dr2w_o` still fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock pin |
| si_i | input | 1 | Serial data input pin |
| cs_n_i | input | 1 | Active-low select pin |
| hold_n_i | input | 1 | Active-low pause pin |
| wp_n_i | input | 1 | Active-low protect for nonvolatile operations |
| addr_i | input | 1 | Strapped device address bit |
| so_o | output | 1 | Serial data output |
| so_oe_o | output | 1 | Drive enable for so_o; when low, the output is high-impedance |
| wiper_val_i | input | DW | Current wiper value, for reads |
| dreg_bank_i | input | 4*DW | Data registers, with entry n at bits [n*DW +: DW] |
| wip_i | input | 1 | Nonvolatile write in progress flag |
| reg_sel_o | output | 2 | Register pointer of the last command |
| wr_data_o | output | DW | Write data for the wiper or a data register |
| wiper_wr_o | output | 1 | Wiper write strobe |
| dreg_wr_o | output | 1 | Data register write strobe |
| xfer_dr2w_o | output | 1 | Register-to-wiper transfer strobe |
| xfer_w2dr_o | output | 1 | Wiper-to-register transfer strobe |
| step_up_o | output | 1 | Wiper step toward the high terminal |
| step_dn_o | output | 1 | Wiper step toward the low terminal |

## Verification
A wrong bit counter or shift state shows up at the ports at the end of the byte it corrupts. A write then carries a rotated value on `wr_data_o`, a read returns a shifted byte on `so_o`, or a strobe arrives one bit early or late. A wrong decode state shows up as a missing, extra or wrong strobe. The bench counts every strobe pulse per transaction, so such an error is reported when that transaction ends. Pause and select errors show within a few clocks of the pin change, as a stuck `so_oe_o` or as steps that keep coming after select rises.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;

    localparam int NPINS    = 5;
    localparam int PIN_SCK  = 0;
    localparam int PIN_SI   = 1;
    localparam int PIN_CS   = 2;
    localparam int PIN_HOLD = 3;
    localparam int PIN_WP   = 4;

    localparam logic [6:0] DEV_TYPE = 7'b0101110;

    typedef enum logic [3:0] {
        OP_STEP     = 4'b0010,
        OP_STATUS   = 4'b0101,
        OP_RD_WIPER = 4'b1001,
        OP_WR_WIPER = 4'b1010,
        OP_RD_DREG  = 4'b1011,
        OP_WR_DREG  = 4'b1100,
        OP_DR2W     = 4'b1101,
        OP_W2DR     = 4'b1110
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_INS,
        ST_WDATA,
        ST_RDATA,
        ST_STEP,
        ST_SKIP
    } state_e;

endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
    parameter int              W       = 5,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int CW = $clog2(STAGES + 2);
    localparam logic [CW-1:0] CNT_MAX = CW'(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
        logic [W-1:0]             prev;
        logic [CW-1:0]            cnt;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d = q;
        d.stg[0] = pins_i;
        for (int i = 1; i < STAGES; i++) begin
            d.stg[i] = q.stg[i-1];
        end
        d.prev = q.stg[STAGES-1];
        if (q.cnt != CNT_MAX) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.stg  <= {STAGES{RST_VAL}};
            q.prev <= RST_VAL;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    // Edges are reported only once the chain holds real pin samples.
    logic primed;
    assign primed = (q.cnt == CNT_MAX);
    assign lvl_o  = q.stg[STAGES-1];
    assign rise_o = primed ? (lvl_o & ~q.prev) : '0;
    assign fall_o = primed ? (~lvl_o & q.prev) : '0;

endmodule

// File: rtl/spi_pot_rx.sv
module spi_pot_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic              si_i,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] byte_val_o
);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [BW-1:0] LAST = BW'(BYTE_W - 1);

    typedef struct packed {
        logic [BW-1:0]     cnt;
        logic [BYTE_W-1:0] sh;
    } rx_t;

    rx_t d, q;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.cnt = '0;
            d.sh  = '0;
        end else if (adv_i) begin
            d.sh  = {q.sh[BYTE_W-2:0], si_i};
            d.cnt = (q.cnt == LAST) ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_done_o = adv_i && !clr_i && (q.cnt == LAST);
    assign byte_val_o  = {q.sh[BYTE_W-2:0], si_i};

endmodule

// File: rtl/spi_pot_tx.sv
module spi_pot_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              adv_i,
    output logic              so_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic              bit_out;
    } tx_t;

    tx_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.sh = data_i;
        end else if (adv_i) begin
            d.bit_out = q.sh[BYTE_W-1];
            d.sh      = {q.sh[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign so_o = q.bit_out;

endmodule

// File: rtl/spi_pot_ctrl.sv
module spi_pot_ctrl
    import spi_pot_pkg::*;
#(
    parameter int DW     = 6,
    parameter int NREG   = 4,
    parameter int BYTE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_lvl_i,
    input  logic               sck_rise_i,
    input  logic               sck_fall_i,
    input  logic               si_lvl_i,
    input  logic               cs_rise_i,
    input  logic               cs_fall_i,
    input  logic               hold_lvl_i,
    input  logic               wp_lvl_i,
    input  logic               addr_i,
    input  logic               byte_done_i,
    input  logic [BYTE_W-1:0]  byte_val_i,
    input  logic [DW-1:0]      wiper_val_i,
    input  logic [NREG*DW-1:0] dreg_bank_i,
    input  logic               wip_i,
    output logic               rise_en_o,
    output logic               fall_en_o,
    output logic               tx_load_o,
    output logic [BYTE_W-1:0]  tx_data_o,
    output logic               so_oe_o,
    output logic [1:0]         reg_sel_o,
    output logic [DW-1:0]      wr_data_o,
    output logic               wiper_wr_o,
    output logic               dreg_wr_o,
    output logic               dr2w_o,
    output logic               w2dr_o,
    output logic               up_o,
    output logic               dn_o
);
    localparam int PAD = BYTE_W - DW;

    typedef struct packed {
        state_e        st;
        logic          held;
        logic          to_dreg;
        logic [1:0]    sel;
        logic [DW-1:0] wdata;
        logic          wiper_wr;
        logic          dreg_wr;
        logic          dr2w;
        logic          w2dr;
        logic          up;
        logic          dn;
        logic          so_en;
    } ctrl_t;

    ctrl_t d, q;
    logic  live;

    // Bit movement is allowed only inside a live, unpaused frame.
    assign live      = (q.st != ST_IDLE) && !q.held && !cs_rise_i && !cs_fall_i;
    assign rise_en_o = live && sck_rise_i;
    assign fall_en_o = live && sck_fall_i;

    always_comb begin
        d          = q;
        d.wiper_wr = 1'b0;
        d.dreg_wr  = 1'b0;
        d.dr2w     = 1'b0;
        d.w2dr     = 1'b0;
        d.up       = 1'b0;
        d.dn       = 1'b0;
        tx_load_o  = 1'b0;
        tx_data_o  = '0;

        if (cs_fall_i) begin
            d.st   = ST_ID;
            d.held = 1'b0;
        end else if (cs_rise_i || q.st == ST_IDLE) begin
            d.st   = ST_IDLE;
            d.held = 1'b0;
        end else begin
            if (!q.held && !hold_lvl_i && !sck_lvl_i) begin
                d.held = 1'b1;
            end else if (q.held && hold_lvl_i && !sck_lvl_i) begin
                d.held = 1'b0;
            end

            if (rise_en_o) begin
                case (q.st)
                    ST_ID: begin
                        if (byte_done_i) begin
                            d.st = (byte_val_i == {DEV_TYPE, addr_i}) ? ST_INS : ST_SKIP;
                        end
                    end
                    ST_INS: begin
                        if (byte_done_i) begin
                            d.sel = byte_val_i[3:2];
                            d.st  = ST_SKIP;
                            if (byte_val_i[1:0] == 2'b00) begin
                                case (byte_val_i[7:4])
                                    OP_WR_WIPER: begin
                                        d.st      = ST_WDATA;
                                        d.to_dreg = 1'b0;
                                    end
                                    OP_WR_DREG: begin
                                        d.st      = ST_WDATA;
                                        d.to_dreg = 1'b1;
                                    end
                                    OP_RD_WIPER: begin
                                        d.st      = ST_RDATA;
                                        tx_load_o = 1'b1;
                                        tx_data_o = {{PAD{1'b0}}, wiper_val_i};
                                    end
                                    OP_RD_DREG: begin
                                        d.st      = ST_RDATA;
                                        tx_load_o = 1'b1;
                                        tx_data_o = {{PAD{1'b0}},
                                                     dreg_bank_i[byte_val_i[3:2]*DW +: DW]};
                                    end
                                    OP_STATUS: begin
                                        d.st      = ST_RDATA;
                                        tx_load_o = 1'b1;
                                        tx_data_o = {{(BYTE_W-1){1'b0}}, wip_i};
                                    end
                                    OP_DR2W: d.dr2w = 1'b1;
                                    OP_W2DR: d.w2dr = wp_lvl_i;
                                    OP_STEP: d.st   = ST_STEP;
                                    default: d.st   = ST_SKIP;
                                endcase
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (byte_done_i) begin
                            d.wdata = byte_val_i[DW-1:0];
                            d.st    = ST_SKIP;
                            if (q.to_dreg) d.dreg_wr  = wp_lvl_i;
                            else           d.wiper_wr = 1'b1;
                        end
                    end
                    ST_RDATA: begin
                        if (byte_done_i) d.st = ST_SKIP;
                    end
                    ST_STEP: begin
                        d.up = si_lvl_i;
                        d.dn = !si_lvl_i;
                    end
                    default: ;
                endcase
            end
        end

        d.so_en = (d.st == ST_RDATA) && !d.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign so_oe_o    = q.so_en;
    assign reg_sel_o  = q.sel;
    assign wr_data_o  = q.wdata;
    assign wiper_wr_o = q.wiper_wr;
    assign dreg_wr_o  = q.dreg_wr;
    assign dr2w_o     = q.dr2w;
    assign w2dr_o     = q.w2dr;
    assign up_o       = q.up;
    assign dn_o       = q.dn;

endmodule

// File: rtl/spi_pot_decoder.sv
module spi_pot_decoder
    import spi_pot_pkg::*;
#(
    parameter int DW          = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck_i,
    input  logic            si_i,
    input  logic            cs_n_i,
    input  logic            hold_n_i,
    input  logic            wp_n_i,
    input  logic            addr_i,
    output logic            so_o,
    output logic            so_oe_o,
    input  logic [DW-1:0]   wiper_val_i,
    input  logic [4*DW-1:0] dreg_bank_i,
    input  logic            wip_i,
    output logic [1:0]      reg_sel_o,
    output logic [DW-1:0]   wr_data_o,
    output logic            wiper_wr_o,
    output logic            dreg_wr_o,
    output logic            xfer_dr2w_o,
    output logic            xfer_w2dr_o,
    output logic            step_up_o,
    output logic            step_dn_o
);
    localparam int NREG   = 4;
    localparam int BYTE_W = 8;
    localparam logic [NPINS-1:0] PIN_RST = NPINS'((1 << PIN_CS) | (1 << PIN_HOLD) | (1 << PIN_WP));

    logic [NPINS-1:0]  pins, lvl, rise, fall;
    logic              sck_rise, sck_fall, cs_rise, cs_fall, wp_lvl;
    logic              rise_en, fall_en, byte_done, tx_load;
    logic [BYTE_W-1:0] byte_val, tx_data;

    always_comb begin
        pins           = '0;
        pins[PIN_SCK]  = sck_i;
        pins[PIN_SI]   = si_i;
        pins[PIN_CS]   = cs_n_i;
        pins[PIN_HOLD] = hold_n_i;
        pins[PIN_WP]   = wp_n_i;
    end

    spi_pot_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign sck_rise = rise[PIN_SCK];
    assign sck_fall = fall[PIN_SCK];
    assign cs_rise  = rise[PIN_CS];
    assign cs_fall  = fall[PIN_CS];
    assign wp_lvl   = lvl[PIN_WP];

    spi_pot_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (cs_fall),
        .adv_i       (rise_en),
        .si_i        (lvl[PIN_SI]),
        .byte_done_o (byte_done),
        .byte_val_o  (byte_val)
    );

    spi_pot_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tx_load),
        .data_i (tx_data),
        .adv_i  (fall_en),
        .so_o   (so_o)
    );

    spi_pot_ctrl #(.DW(DW), .NREG(NREG), .BYTE_W(BYTE_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_lvl_i   (lvl[PIN_SCK]),
        .sck_rise_i  (sck_rise),
        .sck_fall_i  (sck_fall),
        .si_lvl_i    (lvl[PIN_SI]),
        .cs_rise_i   (cs_rise),
        .cs_fall_i   (cs_fall),
        .hold_lvl_i  (lvl[PIN_HOLD]),
        .wp_lvl_i    (wp_lvl),
        .addr_i      (addr_i),
        .byte_done_i (byte_done),
        .byte_val_i  (byte_val),
        .wiper_val_i (wiper_val_i),
        .dreg_bank_i (dreg_bank_i),
        .wip_i       (wip_i),
        .rise_en_o   (rise_en),
        .fall_en_o   (fall_en),
        .tx_load_o   (tx_load),
        .tx_data_o   (tx_data),
        .so_oe_o     (so_oe_o),
        .reg_sel_o   (reg_sel_o),
        .wr_data_o   (wr_data_o),
        .wiper_wr_o  (wiper_wr_o),
        .dreg_wr_o   (dreg_wr_o),
        .dr2w_o      (xfer_dr2w_o),
        .w2dr_o      (xfer_w2dr_o),
        .up_o        (step_up_o),
        .dn_o        (step_dn_o)
    );

endmodule

// File: rtl/spi_pot_decoder_chk.sv
module spi_pot_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic sck_rise,
    input logic cs_rise,
    input logic wp_lvl,
    input logic so_oe_o,
    input logic wiper_wr_o,
    input logic dreg_wr_o,
    input logic xfer_dr2w_o,
    input logic xfer_w2dr_o,
    input logic step_up_o,
    input logic step_dn_o
);
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wiper_wr_o, dreg_wr_o, xfer_dr2w_o, xfer_w2dr_o, step_up_o, step_dn_o}));

    p_wr_after_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_wr_o || dreg_wr_o || xfer_dr2w_o || xfer_w2dr_o) |-> $past(sck_rise));

    p_step_after_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up_o || step_dn_o) |-> $past(sck_rise));

    p_so_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !so_oe_o);

    p_nv_protect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dreg_wr_o || xfer_w2dr_o) |-> $past(wp_lvl));

endmodule

bind spi_pot_decoder spi_pot_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_rise    (sck_rise),
    .cs_rise     (cs_rise),
    .wp_lvl      (wp_lvl),
    .so_oe_o     (so_oe_o),
    .wiper_wr_o  (wiper_wr_o),
    .dreg_wr_o   (dreg_wr_o),
    .xfer_dr2w_o (xfer_dr2w_o),
    .xfer_w2dr_o (xfer_w2dr_o),
    .step_up_o   (step_up_o),
    .step_dn_o   (step_dn_o)
);

// File: tb/spi_pot_decoder_tb.sv
module spi_pot_decoder_tb;
    localparam int DW = 6;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe, wwr, dwr, d2w, w2d, up, dn;
    logic [1:0] sel;
    logic [DW-1:0] wdata;
    logic [DW-1:0] wiper_val = 6'h2A;
    logic [4*DW-1:0] bank = {6'h3C, 6'h33, 6'h22, 6'h11};

    always #10 clk = ~clk;

    spi_pot_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .si_i(si), .cs_n_i(cs_n),
        .hold_n_i(hold_n), .wp_n_i(wp_n), .addr_i(1'b1), .so_o(so), .so_oe_o(so_oe),
        .wiper_val_i(wiper_val), .dreg_bank_i(bank), .wip_i(1'b1),
        .reg_sel_o(sel), .wr_data_o(wdata), .wiper_wr_o(wwr), .dreg_wr_o(dwr),
        .xfer_dr2w_o(d2w), .xfer_w2dr_o(w2d), .step_up_o(up), .step_dn_o(dn)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int c_w = 0, c_d = 0, c_x = 0, c_y = 0, c_up = 0, c_dn = 0;
    logic [DW-1:0] last_data = '0;
    logic [1:0]    last_sel = '0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (wwr) begin c_w <= c_w + 1; last_data <= wdata; end
        if (dwr) begin c_d <= c_d + 1; last_data <= wdata; last_sel <= sel; end
        if (d2w) begin c_x <= c_x + 1; last_sel <= sel; end
        if (w2d) begin c_y <= c_y + 1; last_sel <= sel; end
        if (up) c_up <= c_up + 1;
        if (dn) c_dn <= c_dn + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        sck = 1'b0; si = b; waitc(HP);
        r = so;
        sck = 1'b1; waitc(HP);
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic rb;
            xbit(b[i], rb);
            r[i] = rb;
        end
    endtask

    task automatic xact(input logic [7:0] id, input logic [7:0] ins, input logic [7:0] dat,
                        input logic three, output logic [7:0] rd);
        logic [7:0] dummy;
        rd = '0;
        cs_n = 1'b0; waitc(HP);
        xbyte(id, dummy);
        xbyte(ins, dummy);
        if (three) xbyte(dat, rd);
        sck = 1'b0; waitc(HP);
        cs_n = 1'b1; waitc(4 * HP);
    endtask

    // kind: 0 none, 1 wiper write, 2 dreg write, 3 dr->wiper, 4 wiper->dr, 5 read
    typedef struct packed {
        logic [7:0] id;
        logic [7:0] ins;
        logic [7:0] dat;
        logic       three;
        logic       wp;
        logic [2:0] kind;
        logic [7:0] xv;
        logic [1:0] xsel;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'h5D, 8'hA0, 8'h15, 1'b1, 1'b1, 3'd1, 8'h15, 2'd0, 4'd3},  // R3 wiper write
        '{8'h5D, 8'hC8, 8'h2E, 1'b1, 1'b1, 3'd2, 8'h2E, 2'd2, 4'd3},  // R3 dreg write
        '{8'h5D, 8'hD4, 8'h00, 1'b0, 1'b1, 3'd3, 8'h00, 2'd1, 4'd4},  // R4 dr->wiper
        '{8'h5D, 8'hEC, 8'h00, 1'b0, 1'b1, 3'd4, 8'h00, 2'd3, 4'd4},  // R4 wiper->dr
        '{8'h5C, 8'hA0, 8'h15, 1'b1, 1'b1, 3'd0, 8'h00, 2'd0, 4'd2},  // R2 address bit wrong
        '{8'h7D, 8'hA0, 8'h15, 1'b1, 1'b1, 3'd0, 8'h00, 2'd0, 4'd2},  // R2 type bits wrong
        '{8'h5D, 8'hF0, 8'h15, 1'b1, 1'b1, 3'd0, 8'h00, 2'd0, 4'd10}, // R10 undefined opcode
        '{8'h5D, 8'hA1, 8'h15, 1'b1, 1'b1, 3'd0, 8'h00, 2'd0, 4'd10}, // R10 low bits set
        '{8'h5D, 8'hC4, 8'h07, 1'b1, 1'b0, 3'd0, 8'h00, 2'd1, 4'd11}, // R11 dreg write blocked
        '{8'h5D, 8'hA0, 8'h09, 1'b1, 1'b0, 3'd1, 8'h09, 2'd0, 4'd11}, // R11 wiper write allowed
        '{8'h5D, 8'hE0, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 2'd0, 4'd11}, // R11 wiper->dr blocked
        '{8'h5D, 8'hD0, 8'h00, 1'b0, 1'b0, 3'd3, 8'h00, 2'd0, 4'd11}, // R11 dr->wiper allowed
        '{8'h5D, 8'h90, 8'h00, 1'b1, 1'b1, 3'd5, 8'h2A, 2'd0, 4'd5},  // R5 read wiper
        '{8'h5D, 8'hBC, 8'h00, 1'b1, 1'b1, 3'd5, 8'h3C, 2'd3, 4'd5},  // R5 read dreg 3
        '{8'h5D, 8'h50, 8'h00, 1'b1, 1'b1, 3'd5, 8'h01, 2'd0, 4'd5}   // R5 read status
    };

    initial begin
        logic [7:0] rd, dummy;
        logic b;
        int w0, d0, x0, y0, u0, n0;
        string tag;

        // R1: reset state, select held low across reset
        waitc(5);
        chk("R1 so_oe in reset", so_oe, 0);
        chk("R1 strobes in reset", wwr | dwr | d2w | w2d | up | dn, 0);
        rst_n = 1'b1; waitc(10);
        xbyte(8'h5D, dummy); xbyte(8'hA0, dummy); xbyte(8'h15, dummy);
        sck = 1'b0; waitc(HP); cs_n = 1'b1; waitc(4 * HP);
        chk("R1 no command without select fall", c_w, 0);

        for (int v = 0; v < NV; v++) begin
            w0 = c_w; d0 = c_d; x0 = c_x; y0 = c_y;
            wp_n = VECS[v].wp; waitc(HP);
            xact(VECS[v].id, VECS[v].ins, VECS[v].dat, VECS[v].three, rd);
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            chk({tag, " strobes"},
                {4'(c_w - w0), 4'(c_d - d0), 4'(c_x - x0), 4'(c_y - y0)},
                {4'(VECS[v].kind == 3'd1), 4'(VECS[v].kind == 3'd2),
                 4'(VECS[v].kind == 3'd3), 4'(VECS[v].kind == 3'd4)});
            if (VECS[v].kind == 3'd1 || VECS[v].kind == 3'd2)
                chk({tag, " data"}, last_data, VECS[v].xv[5:0]);
            if (VECS[v].kind >= 3'd2 && VECS[v].kind <= 3'd4)
                chk({tag, " sel"}, last_sel, VECS[v].xsel);
            if (VECS[v].kind == 3'd5)
                chk({tag, " read byte"}, rd, VECS[v].xv);
            wp_n = 1'b1;
        end

        // R6: enable high while read byte pending, low after select rises
        cs_n = 1'b0; waitc(HP);
        xbyte(8'h5D, dummy); xbyte(8'h90, dummy);
        sck = 1'b0; waitc(HP);
        chk("R6 so_oe during read", so_oe, 1);
        cs_n = 1'b1; waitc(HP);
        chk("R6 so_oe after select rise", so_oe, 0);
        waitc(2 * HP);

        // R7: step stream, then SCK with select high does nothing
        u0 = c_up; n0 = c_dn;
        cs_n = 1'b0; waitc(HP);
        xbyte(8'h5D, dummy); xbyte(8'h20, dummy);
        xbit(1, b); xbit(1, b); xbit(0, b); xbit(1, b); xbit(1, b);
        sck = 1'b0; waitc(HP); cs_n = 1'b1; waitc(2 * HP);
        chk("R7 up steps", c_up - u0, 4);
        chk("R7 down steps", c_dn - n0, 1);
        xbit(1, b); xbit(0, b); sck = 1'b0; waitc(2 * HP);
        chk("R7 no steps after select rise", (c_up - u0) + (c_dn - n0), 5);

        // R8: pause mid-byte during a wiper write
        w0 = c_w;
        cs_n = 1'b0; waitc(HP);
        xbyte(8'h5D, dummy); xbyte(8'hA0, dummy);
        xbit(1'b1, b); xbit(1'b0, b); xbit(1'b1, b);
        sck = 1'b0; waitc(HP);
        hold_n = 1'b0; waitc(HP);
        xbit(1'b1, b); xbit(1'b1, b);
        sck = 1'b0; waitc(HP);
        hold_n = 1'b1; waitc(HP);
        xbit(1'b0, b); xbit(1'b1, b); xbit(1'b0, b); xbit(1'b1, b); xbit(1'b1, b);
        sck = 1'b0; waitc(HP); cs_n = 1'b1; waitc(4 * HP);
        chk("R8 write count with pause", c_w - w0, 1);
        chk("R8 write data with pause", last_data, 6'h2B);

        // R8: pause during a read releases the output and keeps the bit position
        cs_n = 1'b0; waitc(HP);
        xbyte(8'h5D, dummy); xbyte(8'h90, dummy);
        sck = 1'b0; waitc(HP);
        hold_n = 1'b0; waitc(HP);
        chk("R8 so_oe while paused", so_oe, 0);
        hold_n = 1'b1; waitc(HP);
        xbyte(8'h00, rd);
        sck = 1'b0; waitc(HP); cs_n = 1'b1; waitc(4 * HP);
        chk("R8 read after pause", rd, 8'h2A);

        // R9: select rise mid data byte cancels the write
        w0 = c_w;
        cs_n = 1'b0; waitc(HP);
        xbyte(8'h5D, dummy); xbyte(8'hA0, dummy);
        for (int i = 0; i < 5; i++) xbit(1'b1, b);
        sck = 1'b0; waitc(HP); cs_n = 1'b1; waitc(4 * HP);
        chk("R9 cancelled write", c_w - w0, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule